// File: doc/BRIEF.md
# Systolic Matrix Multiply Array

This block multiplies two square integer matrices, C = A x B, on a grid of identical multiply-accumulate cells. After a one-cycle start pulse, the caller presents one column of A and the matching row of B on each of the next N cycles. The block delays lane i of each operand by i cycles at the grid edge, so the operands meet on a diagonal wavefront. A values travel rightward and B values travel downward, one cell per cycle. Every cell multiplies the pair passing through it, adds the product to its own accumulator and hands both operands to its neighbours.

Only the clock paces the grid. Cells far from the top-left corner sit idle until the wavefront reaches them. The last product lands 3N-2 cycles after start. The block then raises a done flag and freezes every accumulator, and all N x N results stay readable in parallel until the next start.

The controller is a four-state machine. IDLE waits after reset. FEED lasts N cycles and takes operands. DRAIN lasts 2N-2 cycles and lets the wavefront finish. DONE holds the results. The transitions are:
- start-accept: any state to FEED when start is high. This also covers restart during a run.
- feed-end: FEED to DRAIN after the N-th feed cycle.
- drain-end: DRAIN to DONE on the last product cycle.

Top module: `sysmm_array`

## Requirements
- R1: After reset, done is low and every result field of c_out is zero. Inputs applied before the first start leave both unchanged.
- R2: The clock edge that samples start high clears every accumulator. In the following cycle, all of c_out reads zero.
- R3: Once done is high, the field c_out[(i*N+j)*AW +: AW] holds the signed sum over k of A[i][k]*B[k][j]. On the k-th cycle after the start edge (k = 0..N-1), lane i of a_in (bits [i*DW +: DW]) carries A[i][k] and lane j of b_in (bits [j*DW +: DW]) carries B[k][j]. All operands are two's complement.
- R4: done rises on exactly the 3N-2-th rising edge after the edge that sampled start.
- R5: While done is high and start stays low, done stays high and c_out does not change, whatever a_in and b_in carry.
- R6: A start during FEED or DRAIN abandons the current product. The next result reflects only the operands fed after the new start, and start always takes the machine to FEED with done low.
- R7: The most negative operands in every position, fed for all N terms, give the exact sum N*2^(2DW-2) with no wraparound. The mixed extreme case (most positive times most negative) also gives its exact negative sum.
- R8: Values on a_in and b_in outside the N feed cycles, in DRAIN, DONE or IDLE, have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle pulse: clear accumulators and begin a product |
| a_in | input | N*DW | One column of A per feed cycle, lane i = row i |
| b_in | input | N*DW | One row of B per feed cycle, lane j = column j |
| done | output | 1 | High from completion until the next start |
| c_out | output | N*N*AW | All accumulators, field (i*N+j) = C[i][j] |

## Verification
The bench builds the block with its defaults: N = 4, DW = 8 and AW = 20. With N = 4, the edge delay lines reach three stages and the wavefront crosses seven diagonals, so done is expected on the tenth edge after start. An 8-bit operand makes the extreme products (-128 x -128, 127 x -128) cheap to drive, and summed over four terms they reach 65536 and -65024. A 20-bit accumulator must hold both without wrapping. Restart in mid-feed and noise during drain and hold are exercised alongside ordinary signed matrices.

// File: rtl/sysmm_pkg.sv
package sysmm_pkg;

    // Controller phases of one matrix product
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FEED  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } sysmm_state_e;

endpackage

// File: rtl/sysmm_pe.sv
// One grid cell: multiply the operands passing through, accumulate,
// and register both operands for the right and lower neighbours.
module sysmm_pe #(
    parameter int DW = 8,
    parameter int AW = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic signed [DW-1:0] a_i,
    input  logic signed [DW-1:0] b_i,
    output logic signed [DW-1:0] a_o,
    output logic signed [DW-1:0] b_o,
    output logic signed [AW-1:0] acc_o
);
    localparam int PW = 2 * DW;

    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] acc_q;
    logic signed [DW-1:0] a_q;
    logic signed [DW-1:0] b_q;

    assign prod = a_i * b_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
        end else if (clr) begin
            acc_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
        end else if (en) begin
            acc_q <= acc_q + AW'(prod);
            a_q   <= a_i;
            b_q   <= b_i;
        end
    end

    assign a_o   = a_q;
    assign b_o   = b_q;
    assign acc_o = acc_q;

endmodule

// File: rtl/sysmm_skew.sv
// Edge skew: lane i is delayed by i cycles; lanes carry zero
// outside the feed window.
module sysmm_skew #(
    parameter int N  = 4,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            feed_en,
    input  logic [N*DW-1:0] lane_i,
    output logic [N*DW-1:0] lane_o
);
    logic [N*DW-1:0] gated;

    assign gated = feed_en ? lane_i : '0;

    for (genvar i = 0; i < N; i++) begin : g_lane
        if (i == 0) begin : g_direct
            assign lane_o[DW-1:0] = gated[DW-1:0];
        end else begin : g_delay
            logic [DW-1:0] pipe [i];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int s = 0; s < i; s++) pipe[s] <= '0;
                end else if (clr) begin
                    for (int s = 0; s < i; s++) pipe[s] <= '0;
                end else begin
                    pipe[0] <= gated[i*DW +: DW];
                    for (int s = 1; s < i; s++) pipe[s] <= pipe[s-1];
                end
            end

            assign lane_o[i*DW +: DW] = pipe[i-1];
        end
    end

endmodule

// File: rtl/sysmm_ctrl.sv
// Sequencer: IDLE -> FEED (N cycles) -> DRAIN (2N-2 cycles) -> DONE.
module sysmm_ctrl
    import sysmm_pkg::*;
#(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic feed_en,
    output logic run_en,
    output logic done
);
    localparam int LAST = 3 * N - 3;
    localparam int CW   = $clog2(LAST + 2);

    sysmm_state_e   state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_FEED: begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == CW'(N - 1)) state_d = ST_DRAIN;    // feed-end
            end
            ST_DRAIN: begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == CW'(LAST)) state_d = ST_DONE;      // drain-end
            end
            ST_DONE: ;
            default: state_d = ST_IDLE;
        endcase
        if (start) begin                                         // start-accept
            state_d = ST_FEED;
            cnt_d   = '0;
        end
    end

    // outputs
    always_comb begin
        feed_en = 1'b0;
        run_en  = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_FEED: begin
                feed_en = 1'b1;
                run_en  = 1'b1;
            end
            ST_DRAIN: run_en = 1'b1;
            ST_DONE:  done   = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/sysmm_array.sv
module sysmm_array #(
    parameter int N  = 4,
    parameter int DW = 8,
    parameter int AW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N*DW-1:0]   a_in,
    input  logic [N*DW-1:0]   b_in,
    output logic              done,
    output logic [N*N*AW-1:0] c_out
);
    logic              feed_en;
    logic              run_en;
    logic [N*DW-1:0]   a_edge;
    logic [N*DW-1:0]   b_edge;

    logic signed [DW-1:0] a_op [N][N];
    logic signed [DW-1:0] b_op [N][N];
    logic signed [DW-1:0] a_nx [N][N];
    logic signed [DW-1:0] b_nx [N][N];
    logic signed [AW-1:0] acc  [N][N];

    sysmm_ctrl #(.N(N)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .feed_en (feed_en),
        .run_en  (run_en),
        .done    (done)
    );

    sysmm_skew #(.N(N), .DW(DW)) u_skew_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start),
        .feed_en (feed_en),
        .lane_i  (a_in),
        .lane_o  (a_edge)
    );

    sysmm_skew #(.N(N), .DW(DW)) u_skew_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start),
        .feed_en (feed_en),
        .lane_i  (b_in),
        .lane_o  (b_edge)
    );

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            if (j == 0) begin : g_a_edge
                assign a_op[i][j] = a_edge[i*DW +: DW];
            end else begin : g_a_link
                assign a_op[i][j] = a_nx[i][j-1];
            end

            if (i == 0) begin : g_b_edge
                assign b_op[i][j] = b_edge[j*DW +: DW];
            end else begin : g_b_link
                assign b_op[i][j] = b_nx[i-1][j];
            end

            sysmm_pe #(.DW(DW), .AW(AW)) u_pe (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (start),
                .en    (run_en),
                .a_i   (a_op[i][j]),
                .b_i   (b_op[i][j]),
                .a_o   (a_nx[i][j]),
                .b_o   (b_nx[i][j]),
                .acc_o (acc[i][j])
            );

            assign c_out[(i*N+j)*AW +: AW] = acc[i][j];
        end
    end

endmodule

// File: rtl/sysmm_chk.sv
module sysmm_chk #(
    parameter int N  = 4,
    parameter int AW = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic [N*N*AW-1:0] c_out
);
    // edges elapsed since the edge that sampled start (saturating)
    logic [7:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_q <= 8'hFF;
        else if (start)           since_q <= 8'd0;
        else if (since_q != 8'hFF) since_q <= since_q + 8'd1;
    end

    // R2
    clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (c_out == '0));

    // R4
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (since_q == 8'(3*N-2)));

    // R5
    done_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R5
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(c_out));

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

endmodule

bind sysmm_array sysmm_chk #(.N(N), .AW(AW)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .done  (done),
    .c_out (c_out)
);

// File: tb/sysmm_array_tb.sv
`timescale 1ns/1ps
module sysmm_array_tb;
    localparam int N  = 4;
    localparam int DW = 8;
    localparam int AW = 20;
    localparam int NE = N * N;
    localparam int NCASE = 4;

    // row-major A and B per case
    localparam int CASE_A [NCASE][NE] = '{
        '{1,0,0,0, 0,1,0,0, 0,0,1,0, 0,0,0,1},
        '{-128,-128,-128,-128, -128,-128,-128,-128, -128,-128,-128,-128, -128,-128,-128,-128},
        '{3,-7,12,0, -1,5,9,-20, 100,-50,25,-12, 7,7,-7,7},
        '{127,127,127,127, 127,127,127,127, 127,127,127,127, 127,127,127,127}
    };
    localparam int CASE_B [NCASE][NE] = '{
        '{1,-2,3,-4, 5,-6,7,-8, 9,-10,11,-12, 13,-14,15,-16},
        '{-128,-128,-128,-128, -128,-128,-128,-128, -128,-128,-128,-128, -128,-128,-128,-128},
        '{-4,8,15,-16, 23,42,-1,2, 0,-9,11,6, -33,64,-127,5},
        '{-128,-128,-128,-128, -128,-128,-128,-128, -128,-128,-128,-128, -128,-128,-128,-128}
    };
    localparam string CASE_REQ [NCASE] = '{"R3", "R7", "R8", "R7"};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [N*DW-1:0]   a_in = '0;
    logic [N*DW-1:0]   b_in = '0;
    logic              done;
    logic [N*N*AW-1:0] c_out;

    int n_chk  = 0;
    int n_fail = 0;
    int cur_a [NE];
    int cur_b [NE];

    always #4 clk = ~clk;

    sysmm_array #(.N(N), .DW(DW), .AW(AW)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .a_in  (a_in),
        .b_in  (b_in),
        .done  (done),
        .c_out (c_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int c_elem(input int i, input int j);
        logic signed [AW-1:0] v;
        v = c_out[(i*N+j)*AW +: AW];
        return int'(v);
    endfunction

    function automatic int exp_elem(input int i, input int j);
        int s = 0;
        for (int k = 0; k < N; k++) s += cur_a[i*N+k] * cur_b[k*N+j];
        return s;
    endfunction

    task automatic load_case(input int c);
        for (int e = 0; e < NE; e++) begin
            cur_a[e] = CASE_A[c][e];
            cur_b[e] = CASE_B[c][e];
        end
    endtask

    task automatic drive_col(input int k);
        for (int i = 0; i < N; i++) a_in[i*DW +: DW] = DW'(cur_a[i*N+k]);
        for (int j = 0; j < N; j++) b_in[j*DW +: DW] = DW'(cur_b[k*N+j]);
    endtask

    task automatic drive_junk();
        a_in = $urandom;
        b_in = $urandom;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // start, feed, wait for done, compare, then hold under noise
    task automatic run_case(input string req);
        int m = 0;
        int lat = -1;
        logic [N*N*AW-1:0] held;
        @(negedge clk);
        start = 1'b1;
        drive_junk();
        while (lat < 0 && m < 40) begin
            @(negedge clk);
            m++;
            if (m == 1) begin
                start = 1'b0;
                check(c_out == '0, "R2", int'(c_out != '0), 0);
            end
            if (done) lat = m - 1;
            if (m <= N) drive_col(m - 1);
            else        drive_junk();
        end
        check(lat == 3*N-2, "R4", lat, 3*N-2);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                check(c_elem(i, j) == exp_elem(i, j), req, c_elem(i, j), exp_elem(i, j));
        held = c_out;
        repeat (5) begin
            @(negedge clk);
            drive_junk();
        end
        check(done == 1'b1, "R5", int'(done), 1);
        check(c_out == held, "R5", int'(c_out != held), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_up();
    end

    initial begin
        // R1: reset state, idle inputs ignored
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            drive_junk();
        end
        check(done == 1'b0, "R1", int'(done), 0);
        check(c_out == '0, "R1", int'(c_out != '0), 0);

        // vector table walk: R3, R7, R8 (noise in drain/hold every run)
        for (int c = 0; c < NCASE; c++) begin
            load_case(c);
            run_case(CASE_REQ[c]);
        end

        // R7 named corner: -128 x -128 over four terms
        load_case(1);
        run_case("R7");
        check(c_elem(N-1, N-1) == 65536, "R7", c_elem(N-1, N-1), 65536);

        // R6: abandon a product mid-feed, restart with other operands
        load_case(2);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        drive_col(0);
        @(negedge clk);
        drive_col(1);
        @(negedge clk);
        drive_col(2);
        check(done == 1'b0, "R6", int'(done), 0);
        load_case(0);
        run_case("R6");

        // R6: restart during drain
        load_case(3);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < N; k++) begin
            drive_col(k);
            @(negedge clk);
        end
        load_case(2);
        run_case("R6");

        finish_up();
    end

endmodule